// File: doc/BRIEF.md
# Masked Instrument Status Register with Service Request

This block holds the status byte of a measuring instrument and decides when the instrument asks a bus controller for attention. Four sources feed it:

- three one-cycle event pulses: a new sample reading, a new control reading, and a sensor channel change;
- one level input that reports an overload or an error.

It also forms a fifth, derived condition. This condition is true while the control reading lies within a programmable band around the setpoint.

An 8-bit enable mask chooses which conditions may set their bits in the status byte. One further mask bit chooses whether any set status bit also raises the service-request line.

Software loads the mask and the band limit through two write strobes. Each new value takes effect from the next clock. The bus logic reads the status byte directly.

A serial-poll strobe acknowledges the request. It clears the latched event bits and releases the request line. The level conditions are re-evaluated one cycle later. If the condition behind the request goes away, the request is also released. Every pin is a plain level or a single-cycle strobe. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `stat_srq_unit`

## Requirements
- R1: After reset the status byte reads 0x00, `srq_o` is 0, the mask reads 0x00 and the band limit is zero. With a zero limit, the band test passes only when the reading equals the setpoint.
- R2: A mask write loads `mask_data_i` at the next clock edge, and `mask_o` shows the new value from then on. The write does not clear latched status bits that are already set.
- R3: Status bits 0, 1 and 3 are latched event bits, fed by `evt_sample_i`, `evt_ctrl_i` and `evt_chan_i` in that order. Each bit is set at the edge that samples its pulse, if the mask bit at the same position is 1. A pulse whose mask bit is 0 leaves the bit at 0.
- R4: Status bit 2 is recomputed at every edge. It equals mask bit 2 AND |reading − setpoint| ≤ limit. The reading and setpoint are signed two's-complement W-bit values in tenths, and the limit is unsigned W-bit.
- R5: Status bit 5 is recomputed at every edge. It equals mask bit 5 AND `fault_i`.
- R6: `srq_o` is registered. It rises one edge after any of status bits 0, 1, 2, 3 or 5 reads 1 while mask bit 6 is 1. It stays 0 whenever mask bit 6 was 0 at the previous edge.
- R7: At the edge that samples `poll_i`, `srq_o` and latched bits 0, 1 and 3 go to 0, and bits 2 and 5 read 0. A latched event sampled at that same edge still sets its bit. Bits 2 and 5 are re-evaluated at the next edge.
- R8: When the cause goes away, the request is released. Once every enabled status bit reads 0, `srq_o` falls at the following edge.
- R9: Status bits 4, 6 and 7 always read 0.
- R10: A limit write loads `lim_data_i` at the next clock edge. The band test uses the new limit from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_sample_i | input | 1 | Pulse: new sample reading available |
| evt_ctrl_i | input | 1 | Pulse: new control reading available |
| evt_chan_i | input | 1 | Pulse: sensor channel changed |
| fault_i | input | 1 | Level: overload or error present |
| reading_i | input | W | Control reading, signed, in tenths |
| setpoint_i | input | W | Setpoint, signed, in tenths |
| lim_wr_i | input | 1 | Strobe: load band limit |
| lim_data_i | input | W | New band limit, unsigned, in tenths |
| mask_wr_i | input | 1 | Strobe: load enable mask |
| mask_data_i | input | 8 | New enable mask |
| poll_i | input | 1 | Serial-poll strobe |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Current enable mask |
| srq_o | output | 1 | Service-request level |

## Verification
Two situations are hard to reach from the ports.

The first is a serial poll that lands in the same cycle as a new event pulse. The stimulus drives the poll and the sample pulse on the same clock. It then checks two things: the bit survives while the request drops, and the request rises again one edge later.

The second is a level condition that is still present across a poll. The bench holds the fault input high through the poll and follows the bit and the request edge by edge as they return.

All 256 mask values are swept with every source active. A grid of readings, setpoints and limits, including the extremes where the difference overflows W bits, covers the band test.

// File: rtl/stat_srq_pkg.sv
package stat_srq_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned B_SAMPLE = 0;
  localparam int unsigned B_CTRL   = 1;
  localparam int unsigned B_BAND   = 2;
  localparam int unsigned B_CHAN   = 3;
  localparam int unsigned B_FAULT  = 5;
  localparam int unsigned B_REQEN  = 6;
  // Positions held until a poll, and positions recomputed every cycle.
  localparam logic [STAT_W-1:0] LATCH_SET = 8'h0B;
  localparam logic [STAT_W-1:0] LEVEL_SET = 8'h24;
  localparam logic [STAT_W-1:0] SRQ_SRC   = LATCH_SET | LEVEL_SET;
endpackage

// File: rtl/stat_band_cmp.sv
module stat_band_cmp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] reading_i,
  input  logic [W-1:0] setpoint_i,
  input  logic [W-1:0] limit_i,
  output logic         in_band_o
);
  localparam int unsigned DW = W + 1;

  logic signed [DW-1:0] diff;
  logic        [DW-1:0] mag;

  // One extra bit keeps the difference exact for any pair of inputs.
  assign diff      = $signed({reading_i[W-1], reading_i}) - $signed({setpoint_i[W-1], setpoint_i});
  assign mag       = diff[DW-1] ? DW'(-diff) : DW'(diff);
  assign in_band_o = (mag <= {1'b0, limit_i});
endmodule

// File: rtl/stat_bit_cell.sv
module stat_bit_cell #(
  parameter bit LATCH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  input  logic clr_i,
  output logic q_o
);
  logic set_now;
  assign set_now = en_i & hit_i;

  generate
    if (LATCH) begin : g_latch
      // A new event wins over a coincident clear so that it is not lost.
      always_ff @(posedge clk_i) begin
        if (!rst_ni)      q_o <= 1'b0;
        else if (set_now) q_o <= 1'b1;
        else if (clr_i)   q_o <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q_o <= 1'b0;
        else         q_o <= set_now & ~clr_i;
      end
    end
  endgenerate
endmodule

// File: rtl/stat_srq_unit.sv
module stat_srq_unit
  import stat_srq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_sample_i,
  input  logic              evt_ctrl_i,
  input  logic              evt_chan_i,
  input  logic              fault_i,
  input  logic [W-1:0]      reading_i,
  input  logic [W-1:0]      setpoint_i,
  input  logic              lim_wr_i,
  input  logic [W-1:0]      lim_data_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_data_i,
  input  logic              poll_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              srq_o
);
  logic [STAT_W-1:0] mask_q;
  logic [W-1:0]      lim_q;
  logic              in_band;
  logic [STAT_W-1:0] hit_vec;
  logic [STAT_W-1:0] stat_q;
  logic              srq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '0;
      lim_q  <= '0;
    end else begin
      if (mask_wr_i) mask_q <= mask_data_i;
      if (lim_wr_i)  lim_q  <= lim_data_i;
    end
  end

  stat_band_cmp #(.W(W)) band_i (
    .reading_i  (reading_i),
    .setpoint_i (setpoint_i),
    .limit_i    (lim_q),
    .in_band_o  (in_band)
  );

  always_comb begin
    hit_vec           = '0;
    hit_vec[B_SAMPLE] = evt_sample_i;
    hit_vec[B_CTRL]   = evt_ctrl_i;
    hit_vec[B_BAND]   = in_band;
    hit_vec[B_CHAN]   = evt_chan_i;
    hit_vec[B_FAULT]  = fault_i;
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (LATCH_SET[i]) begin : g_evt
        stat_bit_cell #(.LATCH(1'b1)) cell_i (
          .clk_i (clk_i), .rst_ni (rst_ni), .en_i (mask_q[i]),
          .hit_i (hit_vec[i]), .clr_i (poll_i), .q_o (stat_q[i])
        );
      end else if (LEVEL_SET[i]) begin : g_lvl
        stat_bit_cell #(.LATCH(1'b0)) cell_i (
          .clk_i (clk_i), .rst_ni (rst_ni), .en_i (mask_q[i]),
          .hit_i (hit_vec[i]), .clr_i (poll_i), .q_o (stat_q[i])
        );
      end else begin : g_rsvd
        // Reserved positions pass their tied-off source through.
        assign stat_q[i] = hit_vec[i];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     srq_q <= 1'b0;
    else if (poll_i) srq_q <= 1'b0;
    else             srq_q <= mask_q[B_REQEN] & (|(stat_q & SRQ_SRC));
  end

  assign status_o = stat_q;
  assign mask_o   = mask_q;
  assign srq_o    = srq_q;
endmodule

// File: rtl/stat_srq_chk.sv
module stat_srq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_sample_i,
  input logic       evt_ctrl_i,
  input logic       evt_chan_i,
  input logic       fault_i,
  input logic       mask_wr_i,
  input logic [7:0] mask_data_i,
  input logic       poll_i,
  input logic [7:0] status_o,
  input logic [7:0] mask_o,
  input logic       srq_o
);
  p_mask_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (mask_o == $past(mask_data_i)));

  p_sample_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_sample_i && mask_o[0]) |=> status_o[0]);

  p_ctrl_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ctrl_i && mask_o[1]) |=> status_o[1]);

  p_chan_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_chan_i && mask_o[3]) |=> status_o[3]);

  p_masked_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_o[0] && !status_o[0]) |=> !status_o[0]);

  p_fault_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i |=> !status_o[5]);

  p_no_req_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_o[6] |=> !srq_o);

  p_poll_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i |=> (!srq_o && !status_o[2] && !status_o[5]));

  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] == 1'b0) && (status_o[7:6] == 2'b00));
endmodule

bind stat_srq_unit stat_srq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_sample_i (evt_sample_i),
  .evt_ctrl_i   (evt_ctrl_i),
  .evt_chan_i   (evt_chan_i),
  .fault_i      (fault_i),
  .mask_wr_i    (mask_wr_i),
  .mask_data_i  (mask_data_i),
  .poll_i       (poll_i),
  .status_o     (status_o),
  .mask_o       (mask_o),
  .srq_o        (srq_o)
);

// File: tb/stat_srq_unit_tb_top.sv
module stat_srq_unit_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         evt_sample_i = 1'b0, evt_ctrl_i = 1'b0, evt_chan_i = 1'b0, fault_i = 1'b0;
  logic [W-1:0] reading_i = '0, setpoint_i = '0, lim_data_i = '0;
  logic         lim_wr_i = 1'b0, mask_wr_i = 1'b0, poll_i = 1'b0;
  logic [7:0]   mask_data_i = '0;
  logic [7:0]   status_o, mask_o;
  logic         srq_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  stat_srq_unit #(.W(W)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_sample_i (evt_sample_i), .evt_ctrl_i (evt_ctrl_i), .evt_chan_i (evt_chan_i),
    .fault_i (fault_i), .reading_i (reading_i), .setpoint_i (setpoint_i),
    .lim_wr_i (lim_wr_i), .lim_data_i (lim_data_i),
    .mask_wr_i (mask_wr_i), .mask_data_i (mask_data_i), .poll_i (poll_i),
    .status_o (status_o), .mask_o (mask_o), .srq_o (srq_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] m);
    mask_wr_i = 1'b1; mask_data_i = m;
    step();
    mask_wr_i = 1'b0;
  endtask

  task automatic wr_lim(input int l);
    lim_wr_i = 1'b1; lim_data_i = W'(l);
    step();
    lim_wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    repeat (3) step();
    // R1: reset state
    chk("R1 status", int'(status_o), 0);
    chk("R1 srq", int'(srq_o), 0);
    chk("R1 mask", int'(mask_o), 0);
    rst_ni = 1'b1;
    step();

    // R1: zero limit after reset means exact equality only
    wr_mask(8'h04);
    reading_i = W'(5); setpoint_i = W'(5);
    step();
    chk("R1 equal in band", int'(status_o[2]), 1);
    reading_i = W'(6);
    step();
    chk("R1 off by one", int'(status_o[2]), 0);

    // Sweep of every mask value with every source active
    for (int m = 0; m < 256; m++) begin
      fault_i = 1'b0; reading_i = W'(1000); setpoint_i = '0;
      poll_i = 1'b1; mask_wr_i = 1'b1; mask_data_i = 8'(m);
      step();
      poll_i = 1'b0; mask_wr_i = 1'b0;
      step();
      chk("R7 cleared", int'(status_o), 0);
      chk("R2 mask loaded", int'(mask_o), m);
      evt_sample_i = 1'b1; evt_ctrl_i = 1'b1; evt_chan_i = 1'b1;
      fault_i = 1'b1; reading_i = '0;
      step();
      evt_sample_i = 1'b0; evt_ctrl_i = 1'b0; evt_chan_i = 1'b0;
      chk("R3 R4 R5 R9 status", int'(status_o), m & 8'h2F);
      chk("R6 srq registered", int'(srq_o), 0);
      step();
      chk("R6 srq", int'(srq_o), ((m & 8'h40) != 0 && (m & 8'h2F) != 0) ? 1 : 0);
      chk("R3 latched held", int'(status_o), m & 8'h2F);
      wr_mask(8'h00);
      chk("R2 mask cleared", int'(mask_o), 0);
      step();
      chk("R2 latched kept", int'(status_o), m & 8'h0B);
    end
    fault_i = 1'b0;

    // R7: poll coinciding with an event
    poll_i = 1'b1; step(); poll_i = 1'b0;
    wr_mask(8'h41);
    evt_sample_i = 1'b1; poll_i = 1'b1;
    step();
    evt_sample_i = 1'b0; poll_i = 1'b0;
    chk("R7 event survives poll", int'(status_o[0]), 1);
    chk("R7 srq dropped", int'(srq_o), 0);
    step();
    chk("R7 srq returns", int'(srq_o), 1);
    poll_i = 1'b1; step(); poll_i = 1'b0;
    chk("R7 poll clears latched", int'(status_o), 0);
    chk("R7 poll clears srq", int'(srq_o), 0);

    // R8: cause removed
    wr_mask(8'h60);
    fault_i = 1'b1;
    step(); step();
    chk("R8 srq up", int'(srq_o), 1);
    fault_i = 1'b0;
    step();
    chk("R8 bit falls", int'(status_o[5]), 0);
    chk("R8 srq still up", int'(srq_o), 1);
    step();
    chk("R8 srq released", int'(srq_o), 0);

    // R7: level condition persisting through a poll
    fault_i = 1'b1;
    step(); step();
    chk("R7 srq before poll", int'(srq_o), 1);
    poll_i = 1'b1; step(); poll_i = 1'b0;
    chk("R7 level zero after poll", int'(status_o[5]), 0);
    chk("R7 srq zero after poll", int'(srq_o), 0);
    step();
    chk("R7 level re-evaluated", int'(status_o[5]), 1);
    chk("R7 srq not yet", int'(srq_o), 0);
    step();
    chk("R7 srq reasserted", int'(srq_o), 1);
    fault_i = 1'b0;

    // R4 R10: band grid
    wr_mask(8'h04);
    for (int l = 0; l <= 5; l++) begin
      wr_lim(l);
      for (int s = -4; s <= 4; s++) begin
        for (int r = -8; r <= 8; r++) begin
          int d;
          reading_i = W'(r); setpoint_i = W'(s);
          step();
          d = (r > s) ? r - s : s - r;
          chk("R4 R10 band", int'(status_o[2]), (d <= l) ? 1 : 0);
        end
      end
    end

    // R4: extremes where the difference exceeds W bits
    wr_lim(65535);
    reading_i = W'(32767); setpoint_i = W'(-32768);
    step();
    chk("R4 extreme in", int'(status_o[2]), 1);
    wr_lim(65534);
    step();
    chk("R10 extreme out", int'(status_o[2]), 0);
    reading_i = W'(-32768); setpoint_i = W'(32767);
    step();
    chk("R4 extreme reversed", int'(status_o[2]), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule